// File: doc/BRIEF.md
# Register-Controlled Incrementing Word Source and Checker

This block sits on a simple word-oriented register bus with a write strobe, a read request and a read-valid that comes one clock after the request. The upper address bits split the space in two. Page 0x00 (byte addresses 0x0000 to 0x00FF) belongs to an external engine: a write there becomes a pass-through strobe, and a read there returns the engine's read data. Page 0x10 (0x1000 to 0x10FF) holds the block's own registers. Any other page reads as zero.

The local registers drive a source and a checker. The source pushes wide words, each made of 32-bit lanes, into a downstream FIFO that has a full flag. The checker drains an upstream FIFO that has an empty flag and compares every word against the same incrementing sequence. Software sets a length in wide-word units and starts a run. It then polls busy, the sticky mismatch flag and the two word counters. A self-clearing soft reset returns the datapath to its start state. A latch catches timer-interrupt pulses until software clears it.

Top module: `patt_regbank`

## Requirements
- R1: A write whose address lies in page 0x00 raises `eng_wr_en` in the same cycle. A write to any other page leaves it low.
- R2: `bus_rd_valid` is high exactly one cycle after `bus_rd_req`, and `bus_rd_data` carries the selected value in that cycle. In page 0x00 the value is `eng_rd_data` as it stood at the request. Unmapped local offsets and other pages read as zero. The read data holds between reads.
- R3: `bus_be` has no effect. Every local write stores all 32 data bits.
- R4: A write to offset 0x00 sets the run length in wide words. A read of offset 0x00 returns the number of words pushed so far. Any write to the command register (offset 0x04) clears that count to zero.
- R5: A command write with bit 0 set starts a run and sets busy (command read bit 0). While busy and not full, one word is pushed per cycle. For word index n, lane k holds 8n+k. Busy drops on the cycle the pushed count reaches the length.
- R6: `tx_wr_en` is never high while `tx_full` is high, and a blocked word is retried unchanged.
- R7: `rx_rd_en` is the inverse of `rx_empty`. The returned word is compared one cycle later against the pattern for the receive count. A mismatch sets a sticky error (command read bit 1). Offset 0x10 reads the receive count, which any command write also clears.
- R8: While command bit 1 was last written as 1, mismatches do not set the error flag. Received words are still counted.
- R9: The error flag is cleared by a command write with bit 0 set, and by the soft reset.
- R10: Writing 1 to bit 0 of offset 0x08 clears both counts, busy and the error flag at once. This bit always reads 0.
- R11: A high `timer_irq` sets a latch that reads at bit 8 of offset 0x08. Writing 1 to that bit clears it, unless `timer_irq` is high in the same cycle.
- R12: Offset 0x0C reads `rx_last_cnt` in bits 4:0, `rx_rd_cnt` in bits 15:5 and `tx_full` in bit 24. Command read bit 2 reflects `conn_on`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_req | input | 1 | Register read request |
| bus_addr | input | AW | Byte address |
| bus_wr_data | input | 32 | Write data |
| bus_be | input | 4 | Byte enables (ignored) |
| bus_rd_data | output | 32 | Registered read data |
| bus_rd_valid | output | 1 | Read data valid |
| eng_wr_en | output | 1 | Pass-through write strobe to the engine page |
| eng_rd_data | input | 32 | Read data from the engine page |
| conn_on | input | 1 | Connection-up status, readable |
| timer_irq | input | 1 | Timer interrupt pulse to latch |
| tx_full | input | 1 | Downstream FIFO full |
| tx_wr_en | output | 1 | Downstream FIFO write |
| tx_wr_data | output | DW | Downstream FIFO data |
| rx_empty | input | 1 | Upstream FIFO empty |
| rx_rd_en | output | 1 | Upstream FIFO read |
| rx_rd_data | input | DW | Upstream FIFO data, valid the cycle after the read |
| rx_rd_cnt | input | RDCNT_W | Upstream FIFO fill count, readable |
| rx_last_cnt | input | LAST_W | Upstream FIFO partial count, readable |

## Verification
The properties assume that no register write lands in the cycle under test whenever they follow a counter or flag across a clock. Such a write can clear the counter or the flag, so the stimulus spaces its writes apart from the cycles being observed. They also assume the upstream FIFO returns data in the cycle after each read. The bench drives `rx_rd_data` on that schedule and only while no register write is pending. The full flag and the interrupt line change only after an edge, so each property sees stable inputs.

// File: rtl/patt_pkg.sv
package patt_pkg;
   localparam int LANE_W = 32;

   typedef enum logic [7:0] {
      OFF_LEN = 8'h00,
      OFF_CMD = 8'h04,
      OFF_RST = 8'h08,
      OFF_FST = 8'h0C,
      OFF_RXN = 8'h10
   } loc_off_e;

   localparam int CMD_GO_BIT    = 0;
   localparam int CMD_NOCHK_BIT = 1;
   localparam int RST_SOFT_BIT  = 0;
   localparam int RST_IRQ_BIT   = 8;
   localparam int FST_FULL_BIT  = 24;
endpackage

// File: rtl/patt_word.sv
module patt_word #(
   parameter int DW = 256
) (
   input  logic [31:0]   idx,
   output logic [DW-1:0] word
);
   import patt_pkg::*;
   localparam int LANES = DW / LANE_W;

   // each lane k of word n carries 8n+k
   for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign word[k*LANE_W +: LANE_W] = {idx[28:0], 3'b000} + 32'(k);
   end
endmodule

// File: rtl/patt_gen.sv
module patt_gen #(
   parameter int DW = 256
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [31:0]   len,
   input  logic          go,
   input  logic          clr,
   input  logic          halt,
   input  logic          full,
   output logic          busy,
   output logic [31:0]   cnt,
   output logic          wr_en,
   output logic [DW-1:0] wr_data
);
   logic [31:0] cnt_nx;

   assign wr_en  = busy & ~full;
   assign cnt_nx = cnt + 32'd1;

   patt_word #(.DW(DW)) u_word (.idx(cnt), .word(wr_data));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else begin
         if (wr_en) begin
            cnt <= cnt_nx;
            if (cnt_nx == len) busy <= 1'b0;
         end
         if (clr)  cnt  <= '0;
         if (halt) busy <= 1'b0;
         if (go)   busy <= 1'b1;
      end
   end
endmodule

// File: rtl/patt_chk.sv
module patt_chk #(
   parameter int DW = 256
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          empty,
   input  logic [DW-1:0] rd_data,
   input  logic          nochk,
   input  logic          clr_cnt,
   input  logic          clr_err,
   output logic          rd_en,
   output logic [31:0]   cnt,
   output logic          err
);
   logic          pend;
   logic [DW-1:0] exp_word;

   assign rd_en = ~empty;

   patt_word #(.DW(DW)) u_word (.idx(cnt), .word(exp_word));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= 1'b0;
         cnt  <= '0;
         err  <= 1'b0;
      end else begin
         pend <= rd_en;
         if (pend) begin
            cnt <= cnt + 32'd1;
            if (!nochk && rd_data != exp_word) err <= 1'b1;
         end
         if (clr_cnt) cnt <= '0;
         if (clr_err) err <= 1'b0;
      end
   end
endmodule

// File: rtl/patt_regbank.sv
module patt_regbank #(
   parameter int DW       = 256,
   parameter int AW       = 16,
   parameter int RDCNT_W  = 11,
   parameter int LAST_W   = 5,
   parameter int LOC_PAGE = 'h10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr_en,
   input  logic               bus_rd_req,
   input  logic [AW-1:0]      bus_addr,
   input  logic [31:0]        bus_wr_data,
   input  logic [3:0]         bus_be,
   output logic [31:0]        bus_rd_data,
   output logic               bus_rd_valid,
   output logic               eng_wr_en,
   input  logic [31:0]        eng_rd_data,
   input  logic               conn_on,
   input  logic               timer_irq,
   input  logic               tx_full,
   output logic               tx_wr_en,
   output logic [DW-1:0]      tx_wr_data,
   input  logic               rx_empty,
   output logic               rx_rd_en,
   input  logic [DW-1:0]      rx_rd_data,
   input  logic [RDCNT_W-1:0] rx_rd_cnt,
   input  logic [LAST_W-1:0]  rx_last_cnt
);
   import patt_pkg::*;

   localparam int PG_W = AW - 8;

   if (DW < LANE_W || (DW % LANE_W) != 0) begin : g_bad_dw
      $error("DW must be a positive multiple of the lane width");
   end
   if (AW < 13) begin : g_bad_aw
      $error("AW too narrow for the local page");
   end
   if (RDCNT_W + LAST_W > FST_FULL_BIT) begin : g_bad_fst
      $error("FIFO count fields overlap the full bit");
   end

   logic [PG_W-1:0] page;
   logic [7:0]      off;
   logic            eng_hit, loc_hit;
   logic            len_wr, cmd_wr, rst_wr;
   logic            soft_rst, go;
   logic [31:0]     len_q;
   logic            nochk_q, irq_q;
   logic            busy, err_q;
   logic [31:0]     tx_cnt, rx_cnt;
   logic [31:0]     fst_word, rd_mux;
   logic            unused_be;

   assign unused_be = ^bus_be;

   assign page    = bus_addr[AW-1:8];
   assign off     = bus_addr[7:0];
   assign eng_hit = (page == '0);
   assign loc_hit = (page == PG_W'(LOC_PAGE));

   assign eng_wr_en = bus_wr_en & eng_hit;
   assign len_wr    = bus_wr_en & loc_hit & (off == OFF_LEN);
   assign cmd_wr    = bus_wr_en & loc_hit & (off == OFF_CMD);
   assign rst_wr    = bus_wr_en & loc_hit & (off == OFF_RST);
   assign soft_rst  = rst_wr & bus_wr_data[RST_SOFT_BIT];
   assign go        = cmd_wr & bus_wr_data[CMD_GO_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q   <= '0;
         nochk_q <= 1'b0;
         irq_q   <= 1'b0;
      end else begin
         if (len_wr) len_q   <= bus_wr_data;
         if (cmd_wr) nochk_q <= bus_wr_data[CMD_NOCHK_BIT];
         if (rst_wr && bus_wr_data[RST_IRQ_BIT]) irq_q <= 1'b0;
         if (timer_irq) irq_q <= 1'b1;
      end
   end

   patt_gen #(.DW(DW)) u_gen (
      .clk     (clk),
      .rst_n   (rst_n),
      .len     (len_q),
      .go      (go),
      .clr     (cmd_wr | soft_rst),
      .halt    (soft_rst),
      .full    (tx_full),
      .busy    (busy),
      .cnt     (tx_cnt),
      .wr_en   (tx_wr_en),
      .wr_data (tx_wr_data)
   );

   patt_chk #(.DW(DW)) u_chk (
      .clk     (clk),
      .rst_n   (rst_n),
      .empty   (rx_empty),
      .rd_data (rx_rd_data),
      .nochk   (nochk_q),
      .clr_cnt (cmd_wr | soft_rst),
      .clr_err (go | soft_rst),
      .rd_en   (rx_rd_en),
      .cnt     (rx_cnt),
      .err     (err_q)
   );

   always_comb begin
      fst_word = '0;
      fst_word[LAST_W-1:0]        = rx_last_cnt;
      fst_word[LAST_W +: RDCNT_W] = rx_rd_cnt;
      fst_word[FST_FULL_BIT]      = tx_full;
   end

   always_comb begin
      rd_mux = '0;
      if (eng_hit) begin
         rd_mux = eng_rd_data;
      end else if (loc_hit) begin
         case (off)
            OFF_LEN: rd_mux = tx_cnt;
            OFF_CMD: rd_mux = {29'd0, conn_on, err_q, busy};
            OFF_RST: rd_mux[RST_IRQ_BIT] = irq_q;
            OFF_FST: rd_mux = fst_word;
            OFF_RXN: rd_mux = rx_cnt;
            default: rd_mux = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rd_data  <= '0;
         bus_rd_valid <= 1'b0;
      end else begin
         bus_rd_valid <= bus_rd_req;
         if (bus_rd_req) bus_rd_data <= rd_mux;
      end
   end
endmodule

// File: rtl/patt_regbank_sva.sv
module patt_regbank_sva #(
   parameter int DW = 256,
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_wr_en,
   input logic          bus_rd_req,
   input logic          bus_rd_valid,
   input logic [AW-1:0] bus_addr,
   input logic          eng_wr_en,
   input logic          tx_full,
   input logic          tx_wr_en,
   input logic [DW-1:0] tx_wr_data,
   input logic          err_flag,
   input logic          irq_flag,
   input logic          timer_irq
);
   assert_engine_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr[AW-1:8] != '0) |-> !eng_wr_en);

   assert_read_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd_req |=> bus_rd_valid);

   assert_lane_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_wr_en && !bus_wr_en) |=> (tx_wr_data[31:0] == $past(tx_wr_data[31:0]) + 32'd8));

   assert_no_push_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_full |-> !tx_wr_en);

   assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (err_flag && !bus_wr_en) |=> err_flag);

   assert_irq_latch_R11: assert property (@(posedge clk) disable iff (!rst_n)
      timer_irq |=> irq_flag);
endmodule

bind patt_regbank patt_regbank_sva #(.DW(DW), .AW(AW)) u_sva (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_wr_en    (bus_wr_en),
   .bus_rd_req   (bus_rd_req),
   .bus_rd_valid (bus_rd_valid),
   .bus_addr     (bus_addr),
   .eng_wr_en    (eng_wr_en),
   .tx_full      (tx_full),
   .tx_wr_en     (tx_wr_en),
   .tx_wr_data   (tx_wr_data),
   .err_flag     (err_q),
   .irq_flag     (irq_q),
   .timer_irq    (timer_irq)
);

// File: tb/patt_regbank_tb.sv
module patt_regbank_tb_top;
   localparam int DW = 256;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr_en = 1'b0, bus_rd_req = 1'b0;
   logic [15:0]   bus_addr = '0;
   logic [31:0]   bus_wr_data = '0;
   logic [3:0]    bus_be = 4'hF;
   logic [31:0]   bus_rd_data;
   logic          bus_rd_valid, eng_wr_en;
   logic [31:0]   eng_rd_data = '0;
   logic          conn_on = 1'b0, timer_irq = 1'b0, tx_full = 1'b0;
   logic          tx_wr_en, rx_rd_en;
   logic [DW-1:0] tx_wr_data;
   logic          rx_empty = 1'b1;
   logic [DW-1:0] rx_rd_data = '0;
   logic [10:0]   rx_rd_cnt = '0;
   logic [4:0]    rx_last_cnt = '0;

   int checks = 0, fails = 0, cyc = 0, pushes = 0;
   int full_mode = 0;
   int unsigned src = 0;
   bit corrupt = 1'b0;

   // reference model state
   logic [31:0]   m_len = 0, m_tx = 0, m_rx = 0, m_rdata = 0;
   bit            m_busy = 0, m_err = 0, m_dis = 0, m_irq = 0, m_pend = 0, m_rvalid = 0;

   always #5 clk = ~clk;

   patt_regbank dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_req(bus_rd_req),
      .bus_addr(bus_addr), .bus_wr_data(bus_wr_data), .bus_be(bus_be),
      .bus_rd_data(bus_rd_data), .bus_rd_valid(bus_rd_valid), .eng_wr_en(eng_wr_en),
      .eng_rd_data(eng_rd_data), .conn_on(conn_on), .timer_irq(timer_irq),
      .tx_full(tx_full), .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data),
      .rx_empty(rx_empty), .rx_rd_en(rx_rd_en), .rx_rd_data(rx_rd_data),
      .rx_rd_cnt(rx_rd_cnt), .rx_last_cnt(rx_last_cnt));

   function automatic logic [DW-1:0] bpat(input int unsigned n);
      logic [DW-1:0] w;
      for (int k = 0; k < DW/32; k++) w[k*32 +: 32] = n*8 + k;
      return w;
   endfunction

   function automatic logic [31:0] model_read(input logic [15:0] a);
      logic [31:0] v = 0;
      if (a[15:8] == 8'h00) v = eng_rd_data;
      else if (a[15:8] == 8'h10) begin
         case (a[7:0])
            8'h00: v = m_tx;
            8'h04: v = {29'd0, conn_on, m_err, m_busy};
            8'h08: v = {23'd0, m_irq, 8'd0};
            8'h0C: v = {7'd0, tx_full, 8'd0, rx_rd_cnt, rx_last_cnt};
            8'h10: v = m_rx;
            default: v = 0;
         endcase
      end
      return v;
   endfunction

   task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   // reference model, advanced on every edge
   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_len = 0; m_tx = 0; m_rx = 0; m_rdata = 0; m_busy = 0; m_err = 0;
         m_dis = 0; m_irq = 0; m_pend = 0; m_rvalid = 0;
      end else begin
         bit loc, txf;
         logic [7:0] o;
         loc = (bus_addr[15:8] == 8'h10);
         o = bus_addr[7:0];
         if (bus_rd_req) m_rdata = model_read(bus_addr);
         m_rvalid = bus_rd_req;
         txf = m_busy && !tx_full;
         if (txf) begin
            m_tx = m_tx + 1;
            if (m_tx == m_len) m_busy = 0;
         end
         if (m_pend) begin
            if (!m_dis && rx_rd_data != bpat(m_rx)) m_err = 1;
            m_rx = m_rx + 1;
         end
         m_pend = !rx_empty;
         if (bus_wr_en && loc && o == 8'h08 && bus_wr_data[8]) m_irq = 0;
         if (timer_irq) m_irq = 1;
         if (bus_wr_en && loc && o == 8'h00) m_len = bus_wr_data;
         if (bus_wr_en && loc && o == 8'h04) begin
            m_tx = 0; m_rx = 0; m_dis = bus_wr_data[1];
            if (bus_wr_data[0]) begin m_busy = 1; m_err = 0; end
         end
         if (bus_wr_en && loc && o == 8'h08 && bus_wr_data[0]) begin
            m_tx = 0; m_rx = 0; m_busy = 0; m_err = 0;
         end
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         check(eng_wr_en == (bus_wr_en && bus_addr[15:8] == 8'h00), "R1 eng_wr_en", eng_wr_en, 0);
         check(bus_rd_valid == m_rvalid, "R2 rd_valid", bus_rd_valid, m_rvalid);
         check(bus_rd_data == m_rdata, "R2 rd_data", bus_rd_data, m_rdata);
         check(tx_wr_en == (m_busy && !tx_full), "R6 tx_wr_en", tx_wr_en, m_busy && !tx_full);
         check(tx_wr_data == bpat(m_tx), "R5 tx_wr_data", tx_wr_data, bpat(m_tx));
         check(rx_rd_en == !rx_empty, "R7 rx_rd_en", rx_rd_en, !rx_empty);
         if (tx_wr_en) pushes++;
      end
   end

   // downstream full pattern
   always @(posedge clk) begin
      #1;
      case (full_mode)
         1: tx_full = (cyc % 5 == 2) || (cyc % 7 == 0);
         2: tx_full = 1'b1;
         default: tx_full = 1'b0;
      endcase
   end

   // upstream data source: word arrives the cycle after each read
   always @(posedge clk) begin
      if (rst_n && !rx_empty) begin
         #1;
         rx_rd_data = bpat(src) ^ (corrupt ? {{(DW-1){1'b0}}, 1'b1} : '0);
         corrupt = 1'b0;
         src++;
      end
   end

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   task automatic wr(input logic [15:0] a, input logic [31:0] d, input logic [3:0] be);
      @(posedge clk); #1;
      bus_wr_en = 1; bus_addr = a; bus_wr_data = d; bus_be = be;
      @(negedge clk);
      check(eng_wr_en == (a[15:8] == 8'h00), "R1 pass-through strobe", eng_wr_en, a[15:8] == 8'h00);
      @(posedge clk); #1;
      bus_wr_en = 0; bus_be = 4'hF;
   endtask

   task automatic rd(input logic [15:0] a, input logic [31:0] exp, input logic [31:0] mask, input string tag);
      @(posedge clk); #1;
      bus_rd_req = 1; bus_addr = a;
      @(posedge clk); #1;
      bus_rd_req = 0;
      @(negedge clk);
      check(bus_rd_valid && ((bus_rd_data & mask) == (exp & mask)), tag, bus_rd_data, exp);
   endtask

   task automatic rx_burst(input int n);
      @(posedge clk); #1;
      rx_empty = 0;
      repeat (n) @(posedge clk);
      #1; rx_empty = 1;
      repeat (3) @(posedge clk);
   endtask

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1;
      rd(16'h1000, 0, 32'hFFFF_FFFF, "R4 reset tx count");
      rd(16'h1004, 0, 32'hFFFF_FFFF, "R10 reset command state");
      // engine page
      wr(16'h0008, 32'h1234, 4'hF);
      eng_rd_data = 32'hA5C3_0F12;
      rd(16'h0030, 32'hA5C3_0F12, 32'hFFFF_FFFF, "R2 engine read");
      // length/start with byte enables off, stalls on full
      full_mode = 1;
      wr(16'h1000, 6, 4'h0);
      pushes = 0;
      wr(16'h1004, 1, 4'h0);
      repeat (60) @(posedge clk);
      check(pushes == 6, "R3 R5 pushed word total", pushes, 6);
      rd(16'h1004, 0, 32'hFFFF_FFFF, "R5 busy cleared");
      rd(16'h1000, 6, 32'hFFFF_FFFF, "R4 tx count readback");
      wr(16'h1004, 0, 4'hF);
      rd(16'h1000, 0, 32'hFFFF_FFFF, "R4 cleared by command write");
      // long run stopped by soft reset
      full_mode = 0;
      wr(16'h1000, 40, 4'hF);
      wr(16'h1004, 1, 4'hF);
      rd(16'h1004, 1, 32'hFFFF_FFFF, "R5 busy during run");
      wr(16'h1008, 1, 4'hF);
      rd(16'h1004, 0, 32'hFFFF_FFFF, "R10 busy cleared by soft reset");
      rd(16'h1000, 0, 32'hFFFF_FFFF, "R10 tx count cleared");
      rd(16'h1008, 0, 32'h0000_0001, "R10 soft reset bit reads 0");
      // receive path
      src = 0;
      rx_burst(10);
      rd(16'h1010, 10, 32'hFFFF_FFFF, "R7 rx count");
      rd(16'h1004, 0, 32'hFFFF_FFFF, "R7 clean data no error");
      corrupt = 1;
      rx_burst(3);
      rd(16'h1010, 13, 32'hFFFF_FFFF, "R7 rx count after bad word");
      rd(16'h1004, 2, 32'hFFFF_FFFF, "R7 mismatch sets error");
      rx_burst(2);
      rd(16'h1004, 2, 32'hFFFF_FFFF, "R7 error sticky");
      wr(16'h1008, 1, 4'hF);
      src = 0;
      rd(16'h1004, 0, 32'hFFFF_FFFF, "R9 error cleared by soft reset");
      rd(16'h1010, 0, 32'hFFFF_FFFF, "R10 rx count cleared");
      wr(16'h1004, 2, 4'hF);
      src = 0;
      corrupt = 1;
      rx_burst(4);
      rd(16'h1004, 0, 32'hFFFF_FFFF, "R8 disabled check ignores mismatch");
      rd(16'h1010, 4, 32'hFFFF_FFFF, "R8 words still counted");
      wr(16'h1004, 0, 4'hF);
      src = 0;
      corrupt = 1;
      rx_burst(2);
      rd(16'h1004, 2, 32'h0000_0002, "R9 error set before start");
      wr(16'h1004, 1, 4'hF);
      src = 0;
      rd(16'h1004, 0, 32'h0000_0002, "R9 start clears error");
      wr(16'h1008, 1, 4'hF);
      // interrupt latch
      @(posedge clk); #1 timer_irq = 1;
      @(posedge clk); #1 timer_irq = 0;
      rd(16'h1008, 32'h100, 32'hFFFF_FFFF, "R11 irq latched");
      wr(16'h1008, 32'h100, 4'hF);
      rd(16'h1008, 0, 32'hFFFF_FFFF, "R11 irq cleared");
      // status fields
      full_mode = 2;
      conn_on = 1; rx_last_cnt = 5'h15; rx_rd_cnt = 11'h2AB;
      repeat (2) @(posedge clk);
      rd(16'h100C, (32'd1 << 24) | (32'h2AB << 5) | 32'h15, 32'hFFFF_FFFF, "R12 fifo status");
      rd(16'h1004, 4, 32'hFFFF_FFFF, "R12 conn_on bit");
      rd(16'h1014, 0, 32'hFFFF_FFFF, "R2 unmapped local offset");
      rd(16'h2000, 0, 32'hFFFF_FFFF, "R2 unmapped page");
      repeat (3) @(posedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule